// File: doc/BRIEF.md
# SPI Flash Page-Write Sequencer

This block sits on the host side of a serial NOR flash and writes a block of bytes into it over a four-wire SPI link. A single `start` pulse hands it a 24-bit start address and a byte count. It then pulls the payload from a ready/valid byte stream. For every piece of the block it sends a write-enable frame. It follows that with a program frame that carries the opcode, the address and the payload. It then reads the device status with a status-read frame until the device reports that it is no longer busy.

The sequencer cuts the transfer into pieces so that no program frame runs past the end of a 256-byte page. Each following piece begins at the start of the next page with its own write-enable frame. The link runs in SPI mode 0, and its clock is the system clock divided by `2*HALF_DIV`. Chip select stays low for at least one SPI clock period before the first clock edge of a frame and after its last edge. Chip select also stays high for the same time between frames. The sequencer ends each request with a one-cycle `done` pulse. If the device is still busy after `MAX_POLLS` status reads, it ends with a one-cycle `err` pulse instead.

`rst_n` is active low and asynchronous. The block expects it to arrive already synchronised to `clk` on release.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `busy_o`, `in_ready`, `done` and `err` are all 0.
- R2: The link uses SPI mode 0. `sclk` is 0 whenever `cs_n` is 1, `mosi` changes only while `sclk` is 0, and every byte is sent MSB first.
- R3: Before each program frame comes a frame of its own that holds exactly one byte, the write-enable opcode 0x06.
- R4: A program frame holds the opcode 0x02, then three address bytes (bits 23:16, then 15:8, then 7:0), then the data bytes in the order the input stream delivered them.
- R5: The length of a program frame is the smaller of the bytes still to be written and 256 minus address bits 7:0. The next frame starts at the address just after the last byte written, which is the next page start, and addresses wrap modulo 2^24.
- R6: A frame carries a whole number of bytes, and `sclk` does not pulse after the eighth bit of the last byte. Between the fall of `cs_n` and the first rising `sclk` edge, and between the last falling `sclk` edge and the rise of `cs_n`, there are at least `2*HALF_DIV` clock cycles.
- R7: After each program frame the sequencer sends status-read frames. Each holds opcode 0x05 and one byte read back on `miso`. It stops once bit 0 of the byte read back (the busy flag) is 0, so a device that reports busy N times gets N+1 status reads.
- R8: `done` is a pulse one cycle long. It goes high exactly `2*HALF_DIV` cycles after `cs_n` rises at the end of the last status-read frame.
- R9: If `MAX_POLLS` status reads in a row all report busy, the sequencer pulses `err` for one cycle, gives no `done`, sends no further frames and returns to idle (`busy_o`=0, `cs_n`=1).
- R10: A `start` with `byte_count` 0 produces a `done` pulse on the next cycle and no frame.
- R11: While `busy_o` is 1, `start` is ignored.
- R12: `in_ready` is 1 only while `cs_n` is 0 and a program frame is waiting for its next data byte. While `in_valid` is 0 at that point, `sclk` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; ignored while busy |
| start_addr | input | 24 | Flash byte address of the first byte |
| byte_count | input | 9 | Number of bytes to write |
| busy_o | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at successful completion |
| err | output | 1 | One-cycle pulse on busy-poll timeout |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_ready | output | 1 | Sequencer takes the byte on this clock |
| sclk | output | 1 | SPI serial clock, idles low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Each result has a fixed due time. `done` goes high exactly `2*HALF_DIV` clocks after the final `cs_n` rise. A zero-length request completes one clock after `start`. The first `sclk` rise of a frame comes `3*HALF_DIV+1` clocks after `cs_n` falls. `cs_n` rises `2*HALF_DIV+1` clocks after the last `sclk` fall.

The bench model of the flash decodes frames on the SPI edges and records the clock count at each `cs_n` and `sclk` transition. It checks these distances against the required minimums and checks the `done` delay exactly. All port sampling happens on the falling clock edge, half a cycle after the registers settle. That includes the mode-0 and `in_ready` rules, which are checked on every clock.

// File: rtl/flash_pw_pkg.sv
`timescale 1ns/1ps
package flash_pw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_XFER,
    PH_HOLD,
    PH_GAP
  } phase_t;

  typedef enum logic [1:0] {
    FR_WREN,
    FR_PROG,
    FR_POLL
  } frame_t;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h05;

endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
// One SPI mode-0 byte: MSB first, mosi updated while sclk low, miso
// sampled on the rising edge. done pulses after the eighth falling edge.
module spi_byte_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(HALF_DIV - 1);

  logic          act_q, act_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic          sclk_q, sclk_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (go) begin
        act_d = 1'b1;
        cnt_d = '0;
        bit_d = '0;
        sh_d  = tx_byte;
      end
    end else if (cnt_q == DLAST) begin
      cnt_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = act_q & sh_q[7];

endmodule

// File: rtl/page_chunk_calc.sv
`timescale 1ns/1ps
// Length of the next program frame: bytes left, capped at page space.
module page_chunk_calc #(
  parameter int CNT_W  = 9,
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] addr_lo,
  input  logic [CNT_W-1:0]  remain,
  output logic [CNT_W-1:0]  chunk
);

  localparam logic [CNT_W-1:0] PAGE_BYTES = CNT_W'(1 << PAGE_W);

  logic [CNT_W-1:0] space;

  always_comb begin
    space = PAGE_BYTES - CNT_W'(addr_lo);
    chunk = (remain < space) ? remain : space;
  end

endmodule

// File: rtl/flash_page_writer.sv
`timescale 1ns/1ps
module flash_page_writer
  import flash_pw_pkg::*;
#(
  parameter int         ADDR_BYTES = 3,
  parameter int         CNT_W      = 9,
  parameter int         PAGE_W     = 8,
  parameter int         HALF_DIV   = 2,
  parameter int         MAX_POLLS  = 1000,
  parameter logic [7:0] BUSY_MASK  = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] start_addr,
  input  logic [CNT_W-1:0]        byte_count,
  output logic                    busy_o,
  output logic                    done,
  output logic                    err,
  input  logic [7:0]              in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    sclk,
  output logic                    cs_n,
  output logic                    mosi,
  input  logic                    miso
);

  localparam int ADDR_W   = 8 * ADDR_BYTES;
  localparam int WAIT_CYC = 2 * HALF_DIV;
  localparam int WC_W     = $clog2(WAIT_CYC + 1);
  localparam int IDX_W    = $clog2(ADDR_BYTES + (1 << PAGE_W) + 2);
  localparam int POLL_W   = $clog2(MAX_POLLS + 1);
  localparam logic [WC_W-1:0]   WLAST = WC_W'(WAIT_CYC - 1);
  localparam logic [IDX_W-1:0]  HDR_LAST = IDX_W'(ADDR_BYTES);
  localparam logic [POLL_W-1:0] PLAST = POLL_W'(MAX_POLLS - 1);

  phase_t            phase_q, phase_d;
  frame_t            frame_q, frame_d;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              launched_q, launched_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              stbusy_q, stbusy_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic             wait_end;
  logic             need_data;
  logic             eng_go;
  logic             eng_done;
  logic [7:0]       eng_rx;
  logic [7:0]       tx_byte;
  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] chunk;

  page_chunk_calc #(
    .CNT_W  (CNT_W),
    .PAGE_W (PAGE_W)
  ) chunk_i (
    .addr_lo (addr_q[PAGE_W-1:0]),
    .remain  (rem_q),
    .chunk   (chunk)
  );

  spi_byte_shifter #(
    .HALF_DIV (HALF_DIV)
  ) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (eng_go),
    .tx_byte (tx_byte),
    .miso    (miso),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (sclk),
    .mosi    (mosi)
  );

  assign wait_end  = (wcnt_q == WLAST);
  assign need_data = (frame_q == FR_PROG) && (idx_q > HDR_LAST);
  assign eng_go    = (phase_q == PH_XFER) && !launched_q && (!need_data || in_valid);
  assign in_ready  = (phase_q == PH_XFER) && !launched_q && need_data;

  always_comb begin
    case (frame_q)
      FR_WREN: last_idx = '0;
      FR_PROG: last_idx = HDR_LAST + IDX_W'(len_q);
      default: last_idx = IDX_W'(1);
    endcase
  end

  // Byte selection within the current frame
  always_comb begin
    tx_byte = 8'h00;
    if (idx_q == '0) begin
      case (frame_q)
        FR_WREN: tx_byte = OP_WREN;
        FR_PROG: tx_byte = OP_PROG;
        default: tx_byte = OP_STATUS;
      endcase
    end else if (frame_q == FR_PROG) begin
      if (need_data) begin
        tx_byte = in_data;
      end else begin
        for (int b = 0; b < ADDR_BYTES; b++) begin
          if (idx_q == IDX_W'(ADDR_BYTES - b)) tx_byte = addr_q[8*b +: 8];
        end
      end
    end
  end

  // Sequencer next state
  always_comb begin
    phase_d    = phase_q;
    frame_d    = frame_q;
    wcnt_d     = wcnt_q;
    idx_d      = idx_q;
    launched_d = launched_q;
    addr_d     = addr_q;
    rem_d      = rem_q;
    len_d      = len_q;
    poll_d     = poll_q;
    stbusy_d   = stbusy_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          if (byte_count == '0) begin
            done_d = 1'b1;
          end else begin
            addr_d  = start_addr;
            rem_d   = byte_count;
            frame_d = FR_WREN;
            phase_d = PH_SETUP;
            wcnt_d  = '0;
          end
        end
      end
      PH_SETUP: begin
        if (wait_end) begin
          wcnt_d     = '0;
          idx_d      = '0;
          launched_d = 1'b0;
          phase_d    = PH_XFER;
          if (frame_q == FR_PROG) len_d = chunk;
        end else begin
          wcnt_d = wcnt_q + WC_W'(1);
        end
      end
      PH_XFER: begin
        if (eng_go) launched_d = 1'b1;
        if (eng_done) begin
          launched_d = 1'b0;
          if (idx_q == last_idx) begin
            phase_d = PH_HOLD;
            wcnt_d  = '0;
            if (frame_q == FR_POLL) stbusy_d = |(eng_rx & BUSY_MASK);
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      PH_HOLD: begin
        if (wait_end) begin
          wcnt_d  = '0;
          phase_d = PH_GAP;
        end else begin
          wcnt_d = wcnt_q + WC_W'(1);
        end
      end
      PH_GAP: begin
        if (!wait_end) begin
          wcnt_d = wcnt_q + WC_W'(1);
        end else begin
          wcnt_d  = '0;
          phase_d = PH_SETUP;
          case (frame_q)
            FR_WREN: frame_d = FR_PROG;
            FR_PROG: begin
              frame_d = FR_POLL;
              poll_d  = '0;
            end
            default: begin
              if (!stbusy_q) begin
                addr_d = addr_q + ADDR_W'(len_q);
                rem_d  = rem_q - len_q;
                if (rem_q == len_q) begin
                  phase_d = PH_IDLE;
                  done_d  = 1'b1;
                end else begin
                  frame_d = FR_WREN;
                end
              end else if (poll_q == PLAST) begin
                phase_d = PH_IDLE;
                err_d   = 1'b1;
              end else begin
                poll_d = poll_q + POLL_W'(1);
              end
            end
          endcase
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    cs_n_d = !((phase_d == PH_SETUP) || (phase_d == PH_XFER) || (phase_d == PH_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      frame_q    <= FR_WREN;
      wcnt_q     <= '0;
      idx_q      <= '0;
      launched_q <= 1'b0;
      addr_q     <= '0;
      rem_q      <= '0;
      len_q      <= '0;
      poll_q     <= '0;
      stbusy_q   <= 1'b0;
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      frame_q    <= frame_d;
      wcnt_q     <= wcnt_d;
      idx_q      <= idx_d;
      launched_q <= launched_d;
      addr_q     <= addr_d;
      rem_q      <= rem_d;
      len_q      <= len_d;
      poll_q     <= poll_d;
      stbusy_q   <= stbusy_d;
      cs_n_q     <= cs_n_d;
      done_q     <= done_d;
      err_q      <= err_d;
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign cs_n   = cs_n_q;
  assign done   = done_q;
  assign err    = err_q;

endmodule

// File: rtl/flash_page_writer_chk.sv
`timescale 1ns/1ps
module flash_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done,
  input logic err,
  input logic in_ready,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R2
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));

  // R12
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cs_n);

  // R9
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n);

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  err_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(busy_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind flash_page_writer flash_page_writer_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done     (done),
  .err      (err),
  .in_ready (in_ready),
  .sclk     (sclk),
  .cs_n     (cs_n),
  .mosi     (mosi)
);

// File: tb/flash_page_writer_tb_top.sv
`timescale 1ns/1ps
module flash_page_writer_tb_top;

  localparam int HALF  = 2;
  localparam int WAITC = 2 * HALF;
  localparam int MAXP  = 6;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic [8:0]  byte_count;
  logic        busy_o, done, err;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic        sclk, cs_n, mosi;
  logic        miso;

  int checks, fails, cyc, seed;
  int src_idx;
  bit take, gap_mode;
  // flash model state
  int nbits, cs_fall_cyc, last_fall_cyc, cs_rise_cyc;
  logic [7:0] cur, stat;
  logic [7:0] fr[$];
  bit wel, stuck;
  int busy_left, busy_init;
  int n_wren, n_poll, n_frames, wel_viol, wren_viol, frame_viol;
  int prog_addr[$], prog_len[$];
  logic [7:0] prog_data[$];
  // per-clock monitor state
  int proto_viol, ready_viol, done_cnt, err_cnt, done_cyc;

  flash_page_writer #(
    .HALF_DIV  (HALF),
    .MAX_POLLS (MAXP)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .byte_count (byte_count),
    .busy_o     (busy_o),
    .done       (done),
    .err        (err),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .miso       (miso)
  );

  function automatic logic [7:0] data_of(int i);
    return 8'((i * 37 + seed) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // miso carries the status byte during the second byte of a frame
  assign miso = (!cs_n && nbits >= 8 && nbits < 16) ? stat[15 - nbits] : 1'b0;

  initial forever begin
    @(negedge cs_n);
    nbits = 0;
    fr.delete();
    cs_fall_cyc = cyc;
    stat = {7'd0, (stuck || busy_left > 0)};
  end

  initial forever begin
    @(posedge sclk);
    if (cs_n) proto_viol++;
    else begin
      if (nbits == 0 && cyc - cs_fall_cyc < WAITC) frame_viol++;
      cur = {cur[6:0], mosi};
      nbits++;
      if (nbits % 8 == 0) fr.push_back(cur);
    end
  end

  initial forever begin
    @(negedge sclk);
    last_fall_cyc = cyc;
  end

  initial forever begin
    @(posedge cs_n);
    cs_rise_cyc = cyc;
    n_frames++;
    if (nbits == 0 || nbits % 8 != 0) frame_viol++;
    if (cyc - last_fall_cyc < WAITC) frame_viol++;
    if (fr.size() > 0) begin
      case (fr[0])
        8'h06: begin
          n_wren++;
          if (fr.size() != 1) wren_viol++;
          wel = 1'b1;
        end
        8'h02: begin
          if (!wel) wel_viol++;
          wel = 1'b0;
          if (fr.size() >= 4) begin
            prog_addr.push_back({8'd0, fr[1], fr[2], fr[3]});
            prog_len.push_back(fr.size() - 4);
            for (int k = 4; k < fr.size(); k++) prog_data.push_back(fr[k]);
          end else frame_viol++;
          busy_left = busy_init;
        end
        8'h05: begin
          n_poll++;
          if (fr.size() != 2) frame_viol++;
          if (busy_left > 0) busy_left--;
        end
        default: frame_viol++;
      endcase
    end
  end

  // per-clock monitor, sampled half a cycle after the registers
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (cs_n && sclk) proto_viol++;
      if (!busy_o && !cs_n) proto_viol++;
      if (in_ready && cs_n) ready_viol++;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (err) err_cnt++;
    end
  end

  // payload source
  initial begin
    in_valid = 1'b0;
    in_data  = 8'h00;
    src_idx  = 0;
    take     = 1'b0;
    forever begin
      @(negedge clk);
      if (take) src_idx++;
      in_valid = gap_mode ? (cyc % 3 != 0) : 1'b1;
      in_data  = data_of(src_idx);
      take     = in_valid && in_ready;
    end
  end

  task automatic clear_model();
    n_wren = 0; n_poll = 0; n_frames = 0;
    wel_viol = 0; wren_viol = 0; frame_viol = 0;
    proto_viol = 0; ready_viol = 0;
    done_cnt = 0; err_cnt = 0; done_cyc = 0;
    wel = 1'b0; busy_left = 0;
    prog_addr.delete(); prog_len.delete(); prog_data.delete();
  endtask

  task automatic run_op(int addr, int cnt, int bpolls, bit stk, bit gaps, bit restart, int sd);
    int exp_addr[$];
    int exp_len[$];
    int a, rem, len, g, nch, bad, total;
    @(negedge clk);
    clear_model();
    busy_init = bpolls;
    stuck     = stk;
    gap_mode  = gaps;
    seed      = sd;
    src_idx   = 0;
    start      = 1'b1;
    start_addr = 24'(addr);
    byte_count = 9'(cnt);
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (200) @(negedge clk);
      start      = 1'b1;
      start_addr = 24'h555500;
      byte_count = 9'd3;
      @(negedge clk);
      start = 1'b0;
    end
    g = 0;
    while (done_cnt + err_cnt == 0 && g < 60000) begin
      @(negedge clk);
      g++;
    end
    repeat (12) @(negedge clk);

    a = addr; rem = cnt; nch = 0;
    while (rem > 0) begin
      len = 256 - (a & 255);
      if (rem < len) len = rem;
      exp_addr.push_back(a);
      exp_len.push_back(len);
      a = (a + len) & 24'hFFFFFF;
      rem -= len;
      nch++;
      if (stk) rem = 0;
    end

    if (stk) begin
      chk(err_cnt == 1, "R9", "err pulses", err_cnt, 1);
      chk(done_cnt == 0, "R9", "done pulses on timeout", done_cnt, 0);
      chk(n_poll == MAXP, "R9", "status reads before timeout", n_poll, MAXP);
      chk(n_frames == 3 + MAXP - 1, "R9", "frames after timeout", n_frames, 2 + MAXP);
    end else begin
      chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
      chk(err_cnt == 0, "R8", "err pulses", err_cnt, 0);
      chk(done_cyc - cs_rise_cyc == WAITC, "R8", "done delay after cs rise",
          done_cyc - cs_rise_cyc, WAITC);
      chk(n_poll == nch * (bpolls + 1), "R7", "status reads", n_poll, nch * (bpolls + 1));
    end
    chk(busy_o == 1'b0 && cs_n == 1'b1, "R9", "idle after request", busy_o, 0);
    chk(prog_addr.size() == nch, "R5", "program frame count", prog_addr.size(), nch);
    for (int i = 0; i < nch && i < prog_addr.size(); i++) begin
      chk(prog_addr[i] == exp_addr[i], "R4", "frame address", prog_addr[i], exp_addr[i]);
      chk(prog_len[i] == exp_len[i], "R5", "frame length", prog_len[i], exp_len[i]);
    end
    total = 0;
    foreach (exp_len[i]) total += exp_len[i];
    chk(prog_data.size() == total, "R4", "payload bytes sent", prog_data.size(), total);
    bad = 0;
    foreach (prog_data[j]) if (prog_data[j] != data_of(j)) bad++;
    chk(bad == 0, "R4", "payload byte mismatches", bad, 0);
    chk(wel_viol == 0 && n_wren == prog_addr.size(), "R3", "write-enable before program",
        n_wren, prog_addr.size());
    chk(wren_viol == 0, "R3", "write-enable frame length errors", wren_viol, 0);
    chk(frame_viol == 0, "R6", "frame framing/setup/hold errors", frame_viol, 0);
    chk(proto_viol == 0, "R2", "mode-0 violations", proto_viol, 0);
    chk(ready_viol == 0, "R12", "in_ready outside frame", ready_viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; seed = 0;
    nbits = 0; cur = 8'h00; stat = 8'h00; stuck = 1'b0; busy_init = 0;
    gap_mode = 1'b0;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0;
    clear_model();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk after reset", {cs_n, sclk}, 2);
    chk(busy_o == 1'b0 && in_ready == 1'b0, "R1", "busy/in_ready after reset",
        {busy_o, in_ready}, 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", {done, err}, 0);

    run_op(24'h123410, 5, 2, 1'b0, 1'b0, 1'b0, 3);     // small partial page
    run_op(24'h000100, 256, 1, 1'b0, 1'b0, 1'b0, 17);  // full aligned page
    run_op(24'h0000F0, 40, 0, 1'b0, 1'b1, 1'b0, 29);   // R5 crossing, stalls (R12)
    run_op(24'h01FFFE, 260, 3, 1'b0, 1'b1, 1'b0, 41);  // R5 three pieces
    run_op(24'hFFFFF8, 12, 1, 1'b0, 1'b0, 1'b0, 53);   // R5 address wrap
    run_op(24'h000200, 8, 0, 1'b1, 1'b0, 1'b0, 67);    // R9 timeout
    run_op(24'h0300FC, 10, 1, 1'b0, 1'b0, 1'b1, 71);   // R11 restart ignored

    // R10 zero-length request
    @(negedge clk);
    clear_model();
    start = 1'b1; start_addr = 24'h000400; byte_count = 9'd0;
    @(negedge clk);
    start = 1'b0;
    chk(done_cnt == 1, "R10", "done on next cycle", done_cnt, 1);
    repeat (20) @(negedge clk);
    chk(n_frames == 0 && busy_o == 1'b0, "R10", "frames for zero count", n_frames, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule